// File: doc/BRIEF.md
# Lockable Dual Comparator Control Register

This block holds the digital side of a pair of analog comparators, called channel A and channel B. A single 32-bit register is written over a simple bus with one write strobe and four byte enables, and read back over a 32-bit data port. Channel A owns bits 15:0 and channel B owns bits 31:16. Each half holds that channel's enable, power mode, inverting-input source code, destination code, polarity and hysteresis level. The block drives all of these fields straight out to the analog and routing fabric.

The raw output bit of each comparator enters the block. The block inverts it when the channel's polarity bit is set. It then gates the result with the enable and decodes the 3-bit destination code into seven one-hot timer feeds. This path is purely combinational, so routing keeps working while the bus clock is stopped. The polarity-adjusted value also goes through a synchronizer. The synchronized copy is shown as a read-only status bit, and each change of it produces a one-clock pulse for the interrupt controller.

Each half has a write-once lock bit. Once the lock is set, that half ignores every write until reset, and the lock bit itself cannot be cleared. The other half can still be written.

Top module: `dual_cmp_ctrl`

## Requirements
- R1: After reset every register bit reads 0, all fourteen routing outputs are low and both edge pulses are low.
- R2: A write updates only the bytes whose byte enable is set. Bit 7 and bit 17 are reserved and always read 0.
- R3: Writing 1 to bit 15 locks channel A. From then on, writes leave bits 15 and 13:0 unchanged, including attempts to clear bit 15, while channel B bytes still accept writes. Only reset clears the lock.
- R4: Writing 1 to bit 31 locks channel B in the same way for bits 31 and 29:16, independent of channel A.
- R5: Bit 14 (channel A) and bit 30 (channel B) read the polarity-adjusted comparator value two clock edges after it changes. Writes to these bits have no effect.
- R6: The destination code sits at bits 10:8 (A) and 26:24 (B). Code 0 drives no output. Code k (1 to 7) drives only routing bit k-1, in this order: timer1 break, timer1 capture 1, timer1 reference clear, timer2 capture 4, timer2 reference clear, timer3 capture 1, timer3 reference clear. The selected bit follows the adjusted comparator value combinationally.
- R7: While the enable bit of a channel is 0 (bit 0 for A, bit 16 for B), all seven of its routing outputs are low.
- R8: Polarity bit 11 (A) or 27 (B) set to 1 inverts the raw comparator value before it reaches the routing outputs and the status bit.
- R9: The field outputs follow the register. Enables come from bits 0 and 16, power mode from bits 3:2 and 19:18, and input source from bits 6:4 and 22:20. Hysteresis comes from bits 13:12 and 29:28, the DAC input switch from bit 1, and window mode from bit 23.
- R10: Each edge output is high for exactly one clock after the synchronized adjusted value of its channel rises or falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_be_i | input | 4 | Byte enables for the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register readback |
| raw_a_i | input | 1 | Raw output of comparator A |
| raw_b_i | input | 1 | Raw output of comparator B |
| route_a_o | output | 7 | One-hot timer feeds of channel A |
| route_b_o | output | 7 | One-hot timer feeds of channel B |
| edge_a_o | output | 1 | Change pulse of channel A |
| edge_b_o | output | 1 | Change pulse of channel B |
| en_a_o | output | 1 | Channel A enable |
| en_b_o | output | 1 | Channel B enable |
| mode_a_o | output | 2 | Channel A power mode |
| mode_b_o | output | 2 | Channel B power mode |
| insel_a_o | output | 3 | Channel A inverting-input source |
| insel_b_o | output | 3 | Channel B inverting-input source |
| hyst_a_o | output | 2 | Channel A hysteresis level |
| hyst_b_o | output | 2 | Channel B hysteresis level |
| dac_sw_o | output | 1 | Switch from channel A non-inverting input to the DAC pin |
| window_o | output | 1 | Window mode: ties channel B's non-inverting input to channel A's |

## Verification
The routing path is driven through every destination code with both polarities, each raw level and the enable on and off, on both channels. These patterns separate a wrong decode order, a missing inversion and a missing enable gate. Partial byte-enable writes of all ones show which bytes and reserved bits can change. Lock sequences, including a try to clear the lock and a write to the opposite half, tell a per-half freeze apart from a whole-register freeze. Rising and falling raw steps show the synchronizer latency on the status bit and the one-cycle width of the edge pulse.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;

    localparam int HALF_W  = 16;
    localparam int SEL_W   = 3;
    localparam int DEST_N  = (1 << SEL_W) - 1;
    localparam int MODE_W  = 2;
    localparam int HYST_W  = 2;
    localparam int BYTES_H = HALF_W / 8;

    // Field positions inside one 16-bit half
    localparam int F_EN    = 0;
    localparam int F_AUX   = 1;   // DAC switch in half A, reserved in half B
    localparam int F_MODE  = 2;
    localparam int F_INSEL = 4;
    localparam int F_SPARE = 7;   // reserved in half A, window enable in half B
    localparam int F_DEST  = 8;
    localparam int F_POL   = 11;
    localparam int F_HYST  = 12;
    localparam int F_STAT  = 14;
    localparam int F_LOCK  = 15;

    // Writable bits per half (status and reserved bits excluded)
    localparam logic [HALF_W-1:0] WMASK_A = 16'hBF7F;
    localparam logic [HALF_W-1:0] WMASK_B = 16'hBFFD;

    typedef struct packed {
        logic              lock;
        logic [HYST_W-1:0] hyst;
        logic              pol;
        logic [SEL_W-1:0]  dest;
        logic              spare;
        logic [SEL_W-1:0]  insel;
        logic [MODE_W-1:0] mode;
        logic              aux;
        logic              en;
    } half_cfg_t;

    function automatic half_cfg_t unpack_half(input logic [HALF_W-1:0] b);
        half_cfg_t c;
        c.lock  = b[F_LOCK];
        c.hyst  = b[F_HYST +: HYST_W];
        c.pol   = b[F_POL];
        c.dest  = b[F_DEST +: SEL_W];
        c.spare = b[F_SPARE];
        c.insel = b[F_INSEL +: SEL_W];
        c.mode  = b[F_MODE +: MODE_W];
        c.aux   = b[F_AUX];
        c.en    = b[F_EN];
        return c;
    endfunction

endpackage

// File: rtl/cmpctl_half_reg.sv
module cmpctl_half_reg
    import cmpctl_pkg::*;
#(
    parameter logic [HALF_W-1:0] WR_MASK = WMASK_A
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [BYTES_H-1:0] wr_be_i,
    input  logic [HALF_W-1:0]  wr_data_i,
    input  logic               stat_i,
    output logic [HALF_W-1:0]  bits_o,
    output logic [HALF_W-1:0]  rd_o
);

    typedef struct packed {
        logic [HALF_W-1:0] bits;
    } hreg_t;

    hreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !st_q.bits[F_LOCK]) begin
            for (int b = 0; b < BYTES_H; b++) begin
                if (wr_be_i[b]) begin
                    st_d.bits[b*8 +: 8] = wr_data_i[b*8 +: 8] & WR_MASK[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bits_o         = st_q.bits;
        rd_o           = st_q.bits;
        rd_o[F_STAT]   = stat_i;
    end

endmodule

// File: rtl/cmpctl_route.sv
module cmpctl_route
    import cmpctl_pkg::*;
(
    input  logic              raw_i,
    input  logic              pol_i,
    input  logic              en_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              adj_o,
    output logic [DEST_N-1:0] dest_o
);

    logic live;

    assign adj_o = raw_i ^ pol_i;
    assign live  = adj_o & en_i;

    for (genvar k = 0; k < DEST_N; k++) begin : g_dest
        localparam logic [SEL_W-1:0] CODE = SEL_W'(k + 1);
        assign dest_o[k] = live & (sel_i == CODE);
    end

endmodule

// File: rtl/cmpctl_sync_edge.sv
module cmpctl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
    assign edge_o = st_q.chain[STAGES-1] ^ st_q.prev;

endmodule

// File: rtl/dual_cmp_ctrl.sv
module dual_cmp_ctrl
    import cmpctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_be_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    input  logic              raw_a_i,
    input  logic              raw_b_i,
    output logic [DEST_N-1:0] route_a_o,
    output logic [DEST_N-1:0] route_b_o,
    output logic              edge_a_o,
    output logic              edge_b_o,
    output logic              en_a_o,
    output logic              en_b_o,
    output logic [MODE_W-1:0] mode_a_o,
    output logic [MODE_W-1:0] mode_b_o,
    output logic [SEL_W-1:0]  insel_a_o,
    output logic [SEL_W-1:0]  insel_b_o,
    output logic [HYST_W-1:0] hyst_a_o,
    output logic [HYST_W-1:0] hyst_b_o,
    output logic              dac_sw_o,
    output logic              window_o
);

    localparam int CH_N = 2;

    logic [CH_N-1:0]             raw;
    logic [CH_N-1:0]             adj;
    logic [CH_N-1:0]             stat;
    logic [CH_N-1:0]             pulse;
    logic [CH_N-1:0][HALF_W-1:0] bits;
    logic [CH_N-1:0][HALF_W-1:0] rd;
    logic [CH_N-1:0][DEST_N-1:0] dest;
    half_cfg_t                   cfg [CH_N];

    assign raw = {raw_b_i, raw_a_i};

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        localparam logic [HALF_W-1:0] MASK = (ch == 0) ? WMASK_A : WMASK_B;

        cmpctl_half_reg #(
            .WR_MASK (MASK)
        ) u_reg (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_i),
            .wr_be_i   (wr_be_i[ch*BYTES_H +: BYTES_H]),
            .wr_data_i (wr_data_i[ch*HALF_W +: HALF_W]),
            .stat_i    (stat[ch]),
            .bits_o    (bits[ch]),
            .rd_o      (rd[ch])
        );

        assign cfg[ch] = unpack_half(bits[ch]);

        cmpctl_route u_route (
            .raw_i  (raw[ch]),
            .pol_i  (cfg[ch].pol),
            .en_i   (cfg[ch].en),
            .sel_i  (cfg[ch].dest),
            .adj_o  (adj[ch]),
            .dest_o (dest[ch])
        );

        cmpctl_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (adj[ch]),
            .sync_o  (stat[ch]),
            .edge_o  (pulse[ch])
        );
    end

    assign rd_data_o = {rd[1], rd[0]};

    assign route_a_o = dest[0];
    assign route_b_o = dest[1];
    assign edge_a_o  = pulse[0];
    assign edge_b_o  = pulse[1];
    assign en_a_o    = cfg[0].en;
    assign en_b_o    = cfg[1].en;
    assign mode_a_o  = cfg[0].mode;
    assign mode_b_o  = cfg[1].mode;
    assign insel_a_o = cfg[0].insel;
    assign insel_b_o = cfg[1].insel;
    assign hyst_a_o  = cfg[0].hyst;
    assign hyst_b_o  = cfg[1].hyst;
    assign dac_sw_o  = cfg[0].aux;
    assign window_o  = cfg[1].spare;

endmodule

// File: rtl/dual_cmp_ctrl_chk.sv
module dual_cmp_ctrl_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] rd_data_o,
    input logic [6:0]  route_a_o,
    input logic [6:0]  route_b_o,
    input logic        edge_a_o,
    input logic        edge_b_o
);

    a_r3_lock_a_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[15] |=> $stable({rd_data_o[15], rd_data_o[13:0]}));

    a_r4_lock_b_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[31] |=> $stable({rd_data_o[31], rd_data_o[29:16]}));

    a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[7] == 1'b0) && (rd_data_o[17] == 1'b0));

    a_r6_route_a_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(route_a_o));

    a_r6_route_b_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(route_b_o));

    a_r7_off_a_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_data_o[0] |-> (route_a_o == '0));

    a_r7_off_b_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_data_o[16] |-> (route_b_o == '0));

    a_r10_edge_a_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_a_o == (rd_data_o[14] != $past(rd_data_o[14])));

    a_r10_edge_b_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_b_o == (rd_data_o[30] != $past(rd_data_o[30])));

endmodule

bind dual_cmp_ctrl dual_cmp_ctrl_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_data_o (rd_data_o),
    .route_a_o (route_a_o),
    .route_b_o (route_b_o),
    .edge_a_o  (edge_a_o),
    .edge_b_o  (edge_b_o)
);

// File: tb/dual_cmp_ctrl_tb.sv
module dual_cmp_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_be_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        raw_a_i = 1'b0;
    logic        raw_b_i = 1'b0;
    logic [6:0]  route_a_o, route_b_o;
    logic        edge_a_o, edge_b_o, en_a_o, en_b_o;
    logic [1:0]  mode_a_o, mode_b_o, hyst_a_o, hyst_b_o;
    logic [2:0]  insel_a_o, insel_b_o;
    logic        dac_sw_o, window_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    dual_cmp_ctrl u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_be_i(wr_be_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .raw_a_i(raw_a_i),
        .raw_b_i(raw_b_i), .route_a_o(route_a_o), .route_b_o(route_b_o),
        .edge_a_o(edge_a_o), .edge_b_o(edge_b_o), .en_a_o(en_a_o), .en_b_o(en_b_o),
        .mode_a_o(mode_a_o), .mode_b_o(mode_b_o), .insel_a_o(insel_a_o),
        .insel_b_o(insel_b_o), .hyst_a_o(hyst_a_o), .hyst_b_o(hyst_b_o),
        .dac_sw_o(dac_sw_o), .window_o(window_o)
    );

    // Vector: [12] pol, [11:9] dest code, [8] enable, [7] raw, [6:0] expected routing
    localparam logic [12:0] VEC [12] = '{
        {1'b0, 3'd1, 1'b1, 1'b1, 7'b0000001},
        {1'b0, 3'd2, 1'b1, 1'b1, 7'b0000010},
        {1'b0, 3'd3, 1'b1, 1'b1, 7'b0000100},
        {1'b0, 3'd4, 1'b1, 1'b1, 7'b0001000},
        {1'b0, 3'd5, 1'b1, 1'b1, 7'b0010000},
        {1'b0, 3'd6, 1'b1, 1'b1, 7'b0100000},
        {1'b0, 3'd7, 1'b1, 1'b1, 7'b1000000},
        {1'b0, 3'd0, 1'b1, 1'b1, 7'b0000000},
        {1'b1, 3'd3, 1'b1, 1'b0, 7'b0000100},
        {1'b1, 3'd3, 1'b1, 1'b1, 7'b0000000},
        {1'b0, 3'd5, 1'b0, 1'b1, 7'b0000000},
        {1'b1, 3'd7, 1'b0, 1'b0, 7'b0000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] data, input logic [3:0] be);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_be_i   = be;
        wr_data_i = data;
        @(negedge clk_i);
        wr_en_i   = 1'b0;
        wr_be_i   = '0;
        wr_data_i = '0;
    endtask

    task automatic do_reset();
        raw_a_i = 1'b0;
        raw_b_i = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 readback", rd_data_o, 32'h0);
        chk("R1 routing", {18'h0, route_b_o, route_a_o}, 32'h0);
        chk("R1 edges", {30'h0, edge_b_o, edge_a_o}, 32'h0);

        // R6 R7 R8 routing table on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = 0; i < 12; i++) begin
                logic [15:0] cfg16;
                cfg16 = {4'h0, VEC[i][12], VEC[i][11:9], 7'h0, VEC[i][8]};
                if (ch == 0) wr({16'h0, cfg16}, 4'b0011);
                else         wr({cfg16, 16'h0}, 4'b1100);
                raw_a_i = (ch == 0) ? VEC[i][7] : 1'b0;
                raw_b_i = (ch == 1) ? VEC[i][7] : 1'b0;
                #1;
                if (ch == 0) chk($sformatf("R6/R7/R8 route A vec %0d", i), {25'h0, route_a_o}, {25'h0, VEC[i][6:0]});
                else         chk($sformatf("R6/R7/R8 route B vec %0d", i), {25'h0, route_b_o}, {25'h0, VEC[i][6:0]});
            end
        end

        // R2 R9 byte enables, reserved bits, field outputs
        do_reset();
        wr(32'hFFFF_FFFF, 4'b0001);
        chk("R2 byte0 only", rd_data_o, 32'h0000_007F);
        wr(32'h00FF_0000, 4'b0100);
        chk("R2 byte2 reserved bit17", rd_data_o, 32'h00FD_007F);
        wr(32'h3000_3000, 4'b1010);
        chk("R2 bytes1,3", rd_data_o, 32'h30FD_307F);
        chk("R9 fields A", {21'h0, en_a_o, mode_a_o, insel_a_o, hyst_a_o, dac_sw_o}, {21'h0, 1'b1, 2'd3, 3'd7, 2'd3, 1'b1});
        chk("R9 fields B", {22'h0, en_b_o, mode_b_o, insel_b_o, hyst_b_o, window_o}, {22'h0, 1'b1, 2'd3, 3'd7, 2'd3, 1'b1});
        wr(32'h4000_4000, 4'b1010);
        repeat (2) @(negedge clk_i);
        chk("R5 status not writable", rd_data_o, 32'h00FD_007F);

        // R5 R10 status latency and edge pulses
        do_reset();
        raw_a_i = 1'b1;
        @(negedge clk_i);
        chk("R5 status A after one edge", {31'h0, rd_data_o[14]}, 32'h0);
        chk("R10 no edge A yet", {31'h0, edge_a_o}, 32'h0);
        @(negedge clk_i);
        chk("R5 status A after two edges", {31'h0, rd_data_o[14]}, 32'h1);
        chk("R10 rise pulse A", {31'h0, edge_a_o}, 32'h1);
        @(negedge clk_i);
        chk("R10 pulse A one cycle", {31'h0, edge_a_o}, 32'h0);
        raw_a_i = 1'b0;
        repeat (2) @(negedge clk_i);
        chk("R10 fall pulse A", {31'h0, edge_a_o}, 32'h1);
        chk("R5 status A low", {31'h0, rd_data_o[14]}, 32'h0);
        wr(32'h0000_0800, 4'b0010);
        repeat (3) @(negedge clk_i);
        chk("R8 status A inverted", {31'h0, rd_data_o[14]}, 32'h1);
        raw_b_i = 1'b1;
        repeat (2) @(negedge clk_i);
        chk("R5 status B", {31'h0, rd_data_o[30]}, 32'h1);
        chk("R10 rise pulse B", {31'h0, edge_b_o}, 32'h1);

        // R3 R4 locks
        do_reset();
        wr(32'h0000_8101, 4'b0011);
        chk("R3 lock A set", rd_data_o, 32'h0000_8101);
        wr(32'h0000_0000, 4'b0011);
        chk("R3 lock A holds", rd_data_o, 32'h0000_8101);
        wr(32'h0001_0000, 4'b0100);
        chk("R3 half B still writable", rd_data_o, 32'h0001_8101);
        wr(32'h8000_0000, 4'b1000);
        chk("R4 lock B set", rd_data_o, 32'h8001_8101);
        wr(32'h0000_0000, 4'b1111);
        chk("R4 lock B holds", rd_data_o, 32'h8001_8101);
        raw_a_i = 1'b1;
        #1;
        chk("R3 locked A still routes", {25'h0, route_a_o}, 32'h1);
        do_reset();
        chk("R3 reset clears locks", rd_data_o, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule